// File: doc/BRIEF.md
# Counting Interrupt Request Latch

This block is the capture stage of an eight-input interrupt controller. Each input pin gets raise, drop and pulse events rather than a wire level. The block keeps a small saturating assertion count per pin and derives the pending-request vector from those counts. A per-pin trigger-mode register selects edge or level behaviour. Some pins are wired to edge mode whatever software writes to that register.

When the downstream priority logic grants a pin, an acknowledge strobe with the pin number arrives. The block then updates the pending vector, the in-service vector and the rotation pointer. It does this according to the automatic end-of-interrupt and rotate flags. Priority resolution and command decoding sit outside this block.

Top module: `irq_req_latch`

## Requirements
- R1: Each pin holds a 4-bit count, zero after reset. A raise event adds one and saturates at 15. A drop event subtracts one and holds at 0. A pulse acts as a raise followed by a drop, so a pulse at 15 leaves 14.
- R2: A pin's pending bit in `irr` is set when an event finds the count at 0 and leaves it at 1. For a level-mode pin, it is also set when a raise, drop or pulse leaves the count above zero.
- R3: A drop that takes the count from 1 to 0 leaves the pending bit set.
- R4: While `ready` is low, events change neither counts nor pending bits.
- R5: A write to the trigger-mode register stores `elc_wdata & ELC_MASK` (1 = level), and `elc_rdata` returns the stored value. With the default mask 8'hF8, pins 0–2 stay edge mode. With 8'hDE, pins 0 and 5 stay edge mode.
- R6: An acknowledge of pin p clears `irr[p]` only when pin p's count is zero.
- R7: When `aeoi` is low, an acknowledge of pin p sets `isr[p]`.
- R8: When `aeoi` is high, an acknowledge leaves `isr` unchanged. `rot_ptr` is loaded with p only if `rotate` is also high.
- R9: A drop at count 0 keeps the count at 0 and raises `underflow_err` for exactly the following cycle.
- R10: An event and an acknowledge on the same pin in one cycle apply the count change first, then the zero test of R6.
- R11: Reset clears `irr`, `isr`, `rot_ptr`, `elc_rdata` and `underflow_err`.
- R12: All results appear on the outputs one clock edge after the inputs that cause them. `ev_kind` encodes 0 idle, 1 raise, 2 drop, 3 pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | 1 | Controller initialised; gates pin events |
| ev_kind | input | 2 | Event type: 0 idle, 1 raise, 2 drop, 3 pulse |
| ev_pin | input | 3 | Pin that the event targets |
| elc_we | input | 1 | Trigger-mode register write strobe |
| elc_wdata | input | 8 | Trigger-mode write data, 1 = level |
| elc_rdata | output | 8 | Stored trigger-mode register |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_pin | input | 3 | Acknowledged pin |
| aeoi | input | 1 | Automatic end-of-interrupt flag |
| rotate | input | 1 | Rotation flag |
| irr | output | 8 | Pending request vector |
| isr | output | 8 | In-service vector |
| rot_ptr | output | 3 | Rotation pointer |
| underflow_err | output | 1 | One-cycle pulse on a drop at count zero |

## Verification
Every output is a register that takes its value at the first rising edge after the stimulus. The bench therefore drives a single cycle of inputs at a falling edge. It compares all outputs at the next falling edge, against a model that it advanced once for those same inputs.

The underflow pulse is checked in that same sample and must be gone in the one after it. Counts are not outputs, so the bench observes them through acknowledges: `irr` clears only on an acknowledge at count zero. Saturation and pulse arithmetic are checked by counting drops down to that point.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  typedef enum logic [1:0] {
    PEV_IDLE  = 2'd0,
    PEV_RAISE = 2'd1,
    PEV_DROP  = 2'd2,
    PEV_BLIP  = 2'd3
  } pin_ev_e;
endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
  import irq_req_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_hit,
  input  pin_ev_e          ev_kind,
  input  logic             level,
  input  logic             ack_hit,
  output logic             req_q,
  output logic             uflow_q,
  output logic [CNT_W-1:0] cnt_q
);
  // saturating count arithmetic
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] sat_dec(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_n;
  logic             set_req;
  logic             uflow_n;
  logic             req_n;

  always_comb begin
    cnt_n   = cnt_q;
    set_req = 1'b0;
    uflow_n = 1'b0;
    if (ev_hit) begin
      unique case (ev_kind)
        PEV_RAISE: begin
          cnt_n   = sat_inc(cnt_q);
          set_req = (cnt_q == '0) || level;
        end
        PEV_DROP: begin
          cnt_n   = sat_dec(cnt_q);
          uflow_n = (cnt_q == '0);
          set_req = level && (cnt_n != '0);
        end
        PEV_BLIP: begin
          cnt_n   = sat_dec(sat_inc(cnt_q));
          set_req = (cnt_q == '0) || level;
        end
        default: ;
      endcase
    end
    // count change first, then the acknowledge zero test
    req_n = req_q | set_req;
    if (ack_hit && (cnt_n == '0)) req_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      req_q   <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      req_q   <= req_n;
      uflow_q <= uflow_n;
    end
  end
endmodule

// File: rtl/irq_elc_reg.sv
module irq_elc_reg #(
  parameter int              NPIN = 8,
  parameter logic [NPIN-1:0] MASK = 8'hF8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & MASK;
  end
endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl #(
  parameter int NPIN  = 8,
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  input  logic [PIN_W-1:0] ack_pin,
  input  logic             aeoi,
  input  logic             rotate,
  output logic [NPIN-1:0]  isr_q,
  output logic [PIN_W-1:0] rot_q
);
  logic [NPIN-1:0]  isr_n;
  logic [PIN_W-1:0] rot_n;

  always_comb begin
    isr_n = isr_q;
    rot_n = rot_q;
    if (ack_valid) begin
      if (!aeoi)       isr_n[ack_pin] = 1'b1;
      else if (rotate) rot_n = ack_pin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      rot_q <= '0;
    end else begin
      isr_q <= isr_n;
      rot_q <= rot_n;
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_req_pkg::*;
#(
  parameter int              NPIN     = 8,
  parameter int              CNT_W    = 4,
  parameter logic [NPIN-1:0] ELC_MASK = 8'hF8,
  localparam int             PIN_W    = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [1:0]       ev_kind,
  input  logic [PIN_W-1:0] ev_pin,
  input  logic             elc_we,
  input  logic [NPIN-1:0]  elc_wdata,
  output logic [NPIN-1:0]  elc_rdata,
  input  logic             ack_valid,
  input  logic [PIN_W-1:0] ack_pin,
  input  logic             aeoi,
  input  logic             rotate,
  output logic [NPIN-1:0]  irr,
  output logic [NPIN-1:0]  isr,
  output logic [PIN_W-1:0] rot_ptr,
  output logic             underflow_err
);
  pin_ev_e                ev_k;
  logic [NPIN-1:0]        ev_sel;
  logic [NPIN-1:0]        ack_sel;
  logic [NPIN-1:0]        uflow_vec;
  logic [NPIN*CNT_W-1:0]  cnt_all;

  assign ev_k = pin_ev_e'(ev_kind);

  irq_elc_reg #(.NPIN(NPIN), .MASK(ELC_MASK)) u_elc (
    .clk(clk), .rst_n(rst_n), .we(elc_we), .wdata(elc_wdata), .q(elc_rdata)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign ev_sel[i]  = ready && (ev_k != PEV_IDLE) && (ev_pin == PIN_W'(i));
    assign ack_sel[i] = ack_valid && (ack_pin == PIN_W'(i));

    irq_pin_cell #(.CNT_W(CNT_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .ev_hit(ev_sel[i]), .ev_kind(ev_k),
      .level(elc_rdata[i]), .ack_hit(ack_sel[i]), .req_q(irr[i]),
      .uflow_q(uflow_vec[i]), .cnt_q(cnt_all[i*CNT_W +: CNT_W])
    );
  end

  assign underflow_err = |uflow_vec;

  irq_ack_ctl #(.NPIN(NPIN), .PIN_W(PIN_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_pin(ack_pin),
    .aeoi(aeoi), .rotate(rotate), .isr_q(isr), .rot_q(rot_ptr)
  );
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int              NPIN     = 8,
  parameter int              PIN_W    = 3,
  parameter logic [NPIN-1:0] ELC_MASK = 8'hF8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic [1:0]       ev_kind,
  input logic             ack_valid,
  input logic [PIN_W-1:0] ack_pin,
  input logic             aeoi,
  input logic             rotate,
  input logic [NPIN-1:0]  ack_sel,
  input logic [NPIN-1:0]  irr,
  input logic [NPIN-1:0]  isr,
  input logic [PIN_W-1:0] rot_ptr,
  input logic [NPIN-1:0]  elc_rdata,
  input logic             underflow_err
);
  assert_irr_only_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irr) & ~irr & ~$past(ack_sel)) == '0);

  assert_not_ready_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ready) && !$past(ack_valid)) |-> (irr == $past(irr)));

  assert_elc_forced_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (elc_rdata & ~ELC_MASK) == '0);

  assert_isr_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_valid) && !$past(aeoi)) |-> isr[$past(ack_pin)]);

  assert_aeoi_isr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_valid) && $past(aeoi)) |-> (isr == $past(isr)));

  assert_rot_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_valid) && $past(aeoi) && $past(rotate)) |-> (rot_ptr == $past(ack_pin)));

  assert_err_needs_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |-> ($past(ready) && ($past(ev_kind) == 2'd2)));
endmodule

bind irq_req_latch irq_req_latch_chk #(
  .NPIN(NPIN), .PIN_W(PIN_W), .ELC_MASK(ELC_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .ev_kind(ev_kind),
  .ack_valid(ack_valid), .ack_pin(ack_pin), .aeoi(aeoi), .rotate(rotate),
  .ack_sel(ack_sel), .irr(irr), .isr(isr), .rot_ptr(rot_ptr),
  .elc_rdata(elc_rdata), .underflow_err(underflow_err)
);

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ready = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [2:0] ev_pin = 3'd0;
  logic       elc_we = 1'b0;
  logic [7:0] elc_wdata = 8'h00;
  logic [7:0] elc_rdata;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_pin = 3'd0;
  logic       aeoi = 1'b0;
  logic       rotate = 1'b0;
  logic [7:0] irr, isr;
  logic [2:0] rot_ptr;
  logic       underflow_err;
  logic [7:0] s_elc_rdata, s_irr, s_isr;
  logic [2:0] s_rot;
  logic       s_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int         m_cnt [8];
  logic [7:0] m_irr, m_isr, m_elc;
  logic [2:0] m_rot;
  logic       m_err;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_req_latch u_dut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .ev_kind(ev_kind), .ev_pin(ev_pin),
    .elc_we(elc_we), .elc_wdata(elc_wdata), .elc_rdata(elc_rdata),
    .ack_valid(ack_valid), .ack_pin(ack_pin), .aeoi(aeoi), .rotate(rotate),
    .irr(irr), .isr(isr), .rot_ptr(rot_ptr), .underflow_err(underflow_err)
  );

  irq_req_latch #(.ELC_MASK(8'hDE)) u_dut_slv (
    .clk(clk), .rst_n(rst_n), .ready(ready), .ev_kind(2'd0), .ev_pin(3'd0),
    .elc_we(elc_we), .elc_wdata(elc_wdata), .elc_rdata(s_elc_rdata),
    .ack_valid(1'b0), .ack_pin(3'd0), .aeoi(1'b0), .rotate(1'b0),
    .irr(s_irr), .isr(s_isr), .rot_ptr(s_rot), .underflow_err(s_err)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // reference model, one step per clock for the currently driven inputs
  task automatic model_step();
    m_err = 1'b0;
    if (ready && ev_kind != 2'd0) begin
      int  c   = m_cnt[ev_pin];
      bit  lvl = m_elc[ev_pin];
      int  nc  = c;
      case (ev_kind)
        2'd1: begin
          nc = (c < 15) ? c + 1 : 15;
          if (c == 0 || lvl) m_irr[ev_pin] = 1'b1;
        end
        2'd2: begin
          if (c == 0) m_err = 1'b1;
          nc = (c > 0) ? c - 1 : 0;
          if (lvl && nc > 0) m_irr[ev_pin] = 1'b1;
        end
        default: begin
          nc = (c == 15) ? 14 : c;
          if (c == 0 || lvl) m_irr[ev_pin] = 1'b1;
        end
      endcase
      m_cnt[ev_pin] = nc;
    end
    if (ack_valid) begin
      if (m_cnt[ack_pin] == 0) m_irr[ack_pin] = 1'b0;
      if (!aeoi)       m_isr[ack_pin] = 1'b1;
      else if (rotate) m_rot = ack_pin;
    end
    if (elc_we) m_elc = elc_wdata & 8'hF8;
  endtask

  task automatic compare_all(string req);
    check(req, "irr", int'(irr), int'(m_irr));
    check(req, "isr", int'(isr), int'(m_isr));
    check(req, "rot_ptr", int'(rot_ptr), int'(m_rot));
    check(req, "underflow_err", int'(underflow_err), int'(m_err));
    check(req, "elc_rdata", int'(elc_rdata), int'(m_elc));
  endtask

  // one cycle: drive at falling edge, sample at next falling edge
  task automatic cyc(string req, logic [1:0] k, int p, bit av, int ap);
    ev_kind   = k;
    ev_pin    = 3'(p);
    ack_valid = av;
    ack_pin   = 3'(ap);
    model_step();
    @(posedge clk);
    @(negedge clk);
    ev_kind   = 2'd0;
    ack_valid = 1'b0;
    elc_we    = 1'b0;
    compare_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    m_irr = 0; m_isr = 0; m_elc = 0; m_rot = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "irr", int'(irr), 0);
    check("R11", "isr", int'(isr), 0);
    check("R11", "rot_ptr", int'(rot_ptr), 0);
    check("R11", "elc_rdata", int'(elc_rdata), 0);
    check("R11", "underflow_err", int'(underflow_err), 0);

    // R4 events ignored while not ready
    cyc("R4", 2'd1, 3, 0, 0);
    check("R4", "irr after raise not ready", int'(irr), 0);
    cyc("R4", 2'd3, 5, 0, 0);
    ready = 1'b1;

    // R2 edge set, R3 drop keeps, R6 ack clear at zero, R7 isr
    cyc("R2", 2'd1, 4, 0, 0);
    check("R2", "irr[4]", int'(irr[4]), 1);
    cyc("R3", 2'd2, 4, 0, 0);
    check("R3", "irr[4] after 1->0", int'(irr[4]), 1);
    cyc("R6", 2'd1, 4, 0, 0);
    cyc("R6", 2'd0, 0, 1, 4);
    check("R6", "irr[4] kept count 1", int'(irr[4]), 1);
    check("R7", "isr[4]", int'(isr[4]), 1);
    cyc("R6", 2'd2, 4, 0, 0);
    cyc("R6", 2'd0, 0, 1, 4);
    check("R6", "irr[4] cleared count 0", int'(irr[4]), 0);

    // R1 saturation at 15
    for (int i = 0; i < 16; i++) cyc("R1", 2'd1, 1, 0, 0);
    for (int i = 0; i < 14; i++) cyc("R1", 2'd2, 1, 0, 0);
    cyc("R1", 2'd0, 0, 1, 1);
    check("R1", "irr[1] count 1", int'(irr[1]), 1);
    cyc("R1", 2'd2, 1, 0, 0);
    cyc("R1", 2'd0, 0, 1, 1);
    check("R1", "irr[1] saturated count back to 0", int'(irr[1]), 0);
    // R1 pulse at 15 leaves 14
    for (int i = 0; i < 15; i++) cyc("R1", 2'd1, 0, 0, 0);
    cyc("R1", 2'd3, 0, 0, 0);
    for (int i = 0; i < 14; i++) cyc("R1", 2'd2, 0, 0, 0);
    cyc("R1", 2'd0, 0, 1, 0);
    check("R1", "irr[0] after pulse at 15", int'(irr[0]), 0);

    // R9 underflow
    cyc("R9", 2'd2, 7, 0, 0);
    check("R9", "underflow_err", int'(underflow_err), 1);
    cyc("R9", 2'd0, 0, 0, 0);
    check("R9", "underflow_err drops", int'(underflow_err), 0);

    // R5 trigger-mode masking
    elc_we = 1'b1; elc_wdata = 8'hFF;
    cyc("R5", 2'd0, 0, 0, 0);
    check("R5", "master elc", int'(elc_rdata), 8'hF8);
    check("R5", "slave elc", int'(s_elc_rdata), 8'hDE);
    cyc("R2", 2'd1, 6, 0, 0);
    cyc("R2", 2'd2, 6, 0, 0);

    // R10 same-cycle event and ack
    cyc("R10", 2'd1, 2, 0, 0);
    cyc("R10", 2'd2, 2, 1, 2);
    check("R10", "irr[2] drop+ack", int'(irr[2]), 0);
    cyc("R10", 2'd1, 3, 1, 3);
    check("R10", "irr[3] raise+ack", int'(irr[3]), 1);

    // R8 auto-EOI with and without rotate
    aeoi = 1'b1; rotate = 1'b1;
    cyc("R8", 2'd0, 0, 1, 6);
    check("R8", "rot_ptr", int'(rot_ptr), 6);
    rotate = 1'b0;
    cyc("R8", 2'd0, 0, 1, 2);
    check("R8", "rot_ptr held", int'(rot_ptr), 6);
    aeoi = 1'b0;

    // R12 sweep: pseudo-random traffic compared every cycle
    for (int n = 0; n < 3000; n++) begin
      lfsr   = next_rand(lfsr);
      ready  = (lfsr[3:0] != 4'd0);
      aeoi   = lfsr[4] & lfsr[5];
      rotate = lfsr[6];
      elc_we = (lfsr[11:7] == 5'd0);
      elc_wdata = lfsr[19:12];
      cyc("R12", lfsr[21:20], int'(lfsr[24:22]), lfsr[25] & lfsr[26], int'(lfsr[29:27]));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule